// File: doc/BRIEF.md
# Tiled View Address Generator

This block turns a pixel position inside a two-dimensional tiled container into a 32-bit address in tiled space. The caller supplies a pixel format, a three-bit view orientation and the x and y coordinates, all qualified by a request strobe. One clock later the block returns the address, a flag that marks a coordinate outside the container, and the distance in bytes between two rows as seen through the chosen view.

The address is built from four steps. First, each format discards a number of low coordinate bits. Second, the orientation may mirror either axis. Third, the orientation may swap the two axes. Finally, the row/column offset is aligned to the pixel size, and the format and orientation codes are placed in the top five address bits.

The container size is set by two parameters: the number of width bits and the number of height bits. The input coordinate width is a third parameter. The block has no bus interface and no allocation logic, and it does not translate the address any further.

Top module: `tiled_view_addr_gen`

## Requirements
- R1: A request accepted on a rising edge while `req_valid` is high produces its results, with `rsp_valid` high, exactly one cycle later. When no request is accepted, `rsp_valid` is low in the following cycle and `rsp_addr`, `rsp_range_err` and `rsp_stride` keep their previous values.
- R2: For an in-range request, address bits [28:27] carry the format code: 0 = 8-bit tiled, 1 = 16-bit tiled, 2 = 32-bit tiled.
- R3: For an in-range request, address bits [31:29] carry the orientation code unchanged. Orientation bit 0 mirrors x, bit 1 mirrors y and bit 2 swaps the axes. The codes therefore mean: 0 = 0°, 2 = 0° mirrored, 3 = 180°, 1 = 180° mirrored, 6 = 90°, 7 = 90° mirrored, 5 = 270°, 4 = 270° mirrored.
- R4: The per-format discarded bit counts (x, y) are (0,0) for 8-bit, (0,1) for 16-bit and (1,1) for 32-bit, with 1, 2 and 4 bytes per pixel. The coordinate offset is shifted left by the sum of the two counts before it is placed in address bits [26:0].
- R5: The x field is `CW_BITS` minus the x count bits wide, and the y field is `CH_BITS` minus the y count bits wide. Each field's mask is all ones across that width.
- R6: If x exceeds its mask or y exceeds its mask, the address is zero and `rsp_range_err` is high. Otherwise `rsp_range_err` is low.
- R7: When orientation bit 0 is set, x is XORed with its mask before the offset is formed. When orientation bit 1 is set, y is XORed with its mask.
- R8: Without an axis swap the offset is y shifted left by the x field width, plus x. With a swap it is x shifted left by the y field width, plus y.
- R9: The stride is 1 shifted left by (`CH_BITS` + x count) when the axes are swapped, and by (`CW_BITS` + y count) otherwise.
- R10: A page-mode request (format code 3) returns a zero address, a zero stride and a high `rsp_range_err`, whatever its coordinates.
- R11: While reset is asserted and after it is released, before any request, all four outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_fmt | input | 2 | Pixel format code |
| req_orient | input | 3 | View orientation code |
| req_x | input | COORD_W | Pixel x coordinate |
| req_y | input | COORD_W | Pixel y coordinate |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_addr | output | 32 | Tiled-space address |
| rsp_range_err | output | 1 | Coordinate outside container, or page mode |
| rsp_stride | output | 32 | Row stride in bytes for the selected view |

## Verification
Assertions watch several properties on every cycle:
- the one-cycle latency and the hold of the outputs between requests;
- a zero address whenever the range flag is set;
- the format and orientation fields of in-range results;
- word alignment of 32-bit results;
- the page-mode rejection;
- a stride that is zero or a single power of two.

The bench sweeps every format and orientation over every y value and many x values, and compares each result with an arithmetic model. Only this sweep can show that mirroring, axis swap, field widths, alignment and stride produce the right numbers. Separate scenarios cover the reset values, oversized coordinates and page-mode requests.

// File: rtl/tva_pkg.sv
package tva_pkg;

   typedef enum logic [1:0] {
      TVA_FMT_B8   = 2'd0,
      TVA_FMT_B16  = 2'd1,
      TVA_FMT_B32  = 2'd2,
      TVA_FMT_PAGE = 2'd3
   } tva_fmt_e;

   // per-format geometry resolved from the format code
   typedef struct packed {
      logic [1:0] xs;     // discarded x bits
      logic [1:0] ys;     // discarded y bits
      logic [5:0] xbits;  // x field width
      logic [5:0] ybits;  // y field width
      logic       page;   // page mode, not a 2D view
   } tva_geom_t;

   localparam int unsigned TVA_NUM_FMT   = 4;
   localparam int unsigned TVA_OFF_BITS  = 27;

   function automatic int unsigned tva_xshift(int unsigned f);
      return (f == 2) ? 1 : 0;
   endfunction

   function automatic int unsigned tva_yshift(int unsigned f);
      return (f == 1 || f == 2) ? 1 : 0;
   endfunction

endpackage

// File: rtl/tva_geom.sv
module tva_geom
   import tva_pkg::*;
#(
   parameter int unsigned CW_BITS = 8,
   parameter int unsigned CH_BITS = 7
) (
   input  logic [1:0] fmt,
   output tva_geom_t  geom
);

   tva_geom_t tab [TVA_NUM_FMT];

   for (genvar g = 0; g < TVA_NUM_FMT; g++) begin : g_fmt
      localparam int unsigned XS = tva_xshift(g);
      localparam int unsigned YS = tva_yshift(g);
      assign tab[g] = {2'(XS), 2'(YS), 6'(CW_BITS - XS), 6'(CH_BITS - YS),
                       (g == TVA_NUM_FMT - 1) ? 1'b1 : 1'b0};
   end

   assign geom = tab[fmt];

endmodule

// File: rtl/tva_coord.sv
module tva_coord
   import tva_pkg::*;
#(
   parameter int unsigned COORD_W = 16
) (
   input  tva_geom_t                  geom,
   input  logic [2:0]                 orient,
   input  logic [COORD_W-1:0]         x,
   input  logic [COORD_W-1:0]         y,
   output logic [TVA_OFF_BITS-1:0]    offset,
   output logic                       oor
);

   logic [31:0] x_mask, y_mask, xv, yv, raw, aligned;
   logic [2:0]  align_sh;

   always_comb begin
      x_mask   = (32'd1 << geom.xbits) - 32'd1;
      y_mask   = (32'd1 << geom.ybits) - 32'd1;
      xv       = 32'(x);
      yv       = 32'(y);
      oor      = geom.page || (xv > x_mask) || (yv > y_mask);
      // mirroring
      if (orient[0]) xv = xv ^ x_mask;
      if (orient[1]) yv = yv ^ y_mask;
      // axis order
      if (orient[2]) raw = (xv << geom.ybits) + yv;
      else           raw = (yv << geom.xbits) + xv;
      align_sh = {1'b0, geom.xs} + {1'b0, geom.ys};
      aligned  = raw << align_sh;
      offset   = oor ? '0 : aligned[TVA_OFF_BITS-1:0];
   end

endmodule

// File: rtl/tva_stride.sv
module tva_stride
   import tva_pkg::*;
#(
   parameter int unsigned CW_BITS = 8,
   parameter int unsigned CH_BITS = 7
) (
   input  tva_geom_t   geom,
   input  logic        swap,
   output logic [31:0] stride
);

   logic [5:0] sh;

   always_comb begin
      if (swap) sh = 6'(CH_BITS) + {4'd0, geom.xs};
      else      sh = 6'(CW_BITS) + {4'd0, geom.ys};
      stride = geom.page ? 32'd0 : (32'd1 << sh);
   end

endmodule

// File: rtl/tiled_view_addr_gen.sv
module tiled_view_addr_gen
   import tva_pkg::*;
#(
   parameter int unsigned CW_BITS = 8,
   parameter int unsigned CH_BITS = 7,
   parameter int unsigned COORD_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_fmt,
   input  logic [2:0]         req_orient,
   input  logic [COORD_W-1:0] req_x,
   input  logic [COORD_W-1:0] req_y,
   output logic               rsp_valid,
   output logic [31:0]        rsp_addr,
   output logic               rsp_range_err,
   output logic [31:0]        rsp_stride
);

   localparam int unsigned SPAN_BITS = CW_BITS + CH_BITS;

   // elaboration-time parameter checks
   if (SPAN_BITS > TVA_OFF_BITS) begin : g_bad_span
      $error("container span exceeds the offset field");
   end
   if (CW_BITS < 2 || CH_BITS < 2) begin : g_bad_dim
      $error("container dimensions need at least two bits");
   end
   if (COORD_W < CW_BITS || COORD_W < CH_BITS || COORD_W > 32) begin : g_bad_coord
      $error("coordinate width out of range");
   end

   tva_geom_t                  geom;
   logic [TVA_OFF_BITS-1:0]    offset;
   logic                       oor;
   logic [31:0]                stride;

   tva_geom #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS)) geom_i (
      .fmt  (req_fmt),
      .geom (geom)
   );

   tva_coord #(.COORD_W(COORD_W)) coord_i (
      .geom   (geom),
      .orient (req_orient),
      .x      (req_x),
      .y      (req_y),
      .offset (offset),
      .oor    (oor)
   );

   tva_stride #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS)) stride_i (
      .geom   (geom),
      .swap   (req_orient[2]),
      .stride (stride)
   );

   logic live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_addr      <= '0;
         rsp_range_err <= 1'b0;
         rsp_stride    <= '0;
         live_q        <= 1'b0;
      end else begin
         live_q    <= 1'b1;
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_addr      <= oor ? 32'd0 : {req_orient, req_fmt, offset};
            rsp_range_err <= oor;
            rsp_stride    <= stride;
         end
      end
   end

   // R1
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> (rsp_valid == $past(req_valid)));

   // R1
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !$past(req_valid)) |->
         ($stable(rsp_addr) && $stable(rsp_range_err) && $stable(rsp_stride)));

   // R6
   zero_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_range_err |-> (rsp_addr == 32'd0));

   // R2
   fmt_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(req_valid) && !rsp_range_err) |->
         (rsp_addr[28:27] == $past(req_fmt)));

   // R3
   orient_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(req_valid) && !rsp_range_err) |->
         (rsp_addr[31:29] == $past(req_orient)));

   // R4
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(req_valid) && $past(req_fmt) == 2'd2) |->
         (rsp_addr[1:0] == 2'b00));

   // R10
   page_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(req_valid) && $past(req_fmt) == 2'd3) |->
         (rsp_range_err && rsp_stride == 32'd0));

   // R9
   stride_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_stride));

endmodule

// File: tb/tiled_view_addr_gen_tb_top.sv
module tiled_view_addr_gen_tb_top;

   localparam int unsigned CW = 8;
   localparam int unsigned CH = 7;
   localparam int unsigned CWD = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [1:0]      req_fmt = '0;
   logic [2:0]      req_orient = '0;
   logic [CWD-1:0]  req_x = '0;
   logic [CWD-1:0]  req_y = '0;
   logic            rsp_valid;
   logic [31:0]     rsp_addr;
   logic            rsp_range_err;
   logic [31:0]     rsp_stride;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   tiled_view_addr_gen #(.CW_BITS(CW), .CH_BITS(CH), .COORD_W(CWD)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_fmt       (req_fmt),
      .req_orient    (req_orient),
      .req_x         (req_x),
      .req_y         (req_y),
      .rsp_valid     (rsp_valid),
      .rsp_addr      (rsp_addr),
      .rsp_range_err (rsp_range_err),
      .rsp_stride    (rsp_stride)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // arithmetic reference built from the requirement text
   task automatic model(input int f, input int o, input int x, input int y,
                        output logic [31:0] addr, output logic err,
                        output logic [31:0] stride);
      int xs, ys, xb, yb, xm, ym, xv, yv, off;
      xs = (f == 2) ? 1 : 0;
      ys = (f == 1 || f == 2) ? 1 : 0;
      xb = CW - xs;
      yb = CH - ys;
      xm = (2 ** xb) - 1;
      ym = (2 ** yb) - 1;
      err = (f == 3) || (x > xm) || (y > ym);
      if (f == 3) stride = 0;
      else if (o >= 4) stride = 2 ** (CH + xs);
      else stride = 2 ** (CW + ys);
      xv = (o % 2 == 1) ? (xm - x) : x;
      yv = ((o / 2) % 2 == 1) ? (ym - y) : y;
      if (o >= 4) off = xv * (2 ** yb) + yv;
      else        off = yv * (2 ** xb) + xv;
      off = off * (2 ** (xs + ys));
      if (err) addr = 32'd0;
      else     addr = (o * (2 ** 29)) + (f * (2 ** 27)) + off;
   endtask

   task automatic do_req(input int f, input int o, input int x, input int y);
      logic [31:0] ea, es;
      logic        ee;
      string       otag;
      @(negedge clk);
      req_valid  = 1'b1;
      req_fmt    = 2'(f);
      req_orient = 3'(o);
      req_x      = CWD'(x);
      req_y      = CWD'(y);
      @(negedge clk);
      req_valid  = 1'b0;
      model(f, o, x, y, ea, ee, es);
      chk("R1 valid", {31'd0, rsp_valid}, 32'd1);
      if (f == 3) begin
         chk("R10 addr", rsp_addr, 32'd0);
         chk("R10 err", {31'd0, rsp_range_err}, 32'd1);
         chk("R10 stride", rsp_stride, 32'd0);
      end else if (ee) begin
         chk("R6 addr", rsp_addr, 32'd0);
         chk("R6 err", {31'd0, rsp_range_err}, 32'd1);
         chk("R9 stride", rsp_stride, es);
      end else begin
         chk("R6 err", {31'd0, rsp_range_err}, 32'd0);
         chk("R2 fmt field", {30'd0, rsp_addr[28:27]}, {30'd0, ea[28:27]});
         chk("R3 orient field", {29'd0, rsp_addr[31:29]}, {29'd0, ea[31:29]});
         if (o >= 4)           otag = "R8 offset";
         else if (o % 4 != 0)  otag = "R7 offset";
         else if (f != 0)      otag = "R4 offset";
         else                  otag = "R5 offset";
         chk(otag, {5'd0, rsp_addr[26:0]}, {5'd0, ea[26:0]});
         chk("R9 stride", rsp_stride, es);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] a0, s0;
      logic        e0;
      // R11 reset values
      repeat (3) @(negedge clk);
      chk("R11 valid", {31'd0, rsp_valid}, 32'd0);
      chk("R11 addr", rsp_addr, 32'd0);
      chk("R11 err", {31'd0, rsp_range_err}, 32'd0);
      chk("R11 stride", rsp_stride, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 idle addr", rsp_addr, 32'd0);
      chk("R11 idle stride", rsp_stride, 32'd0);

      // sweep over formats, orientations and coordinates (R2..R9)
      for (int f = 0; f < 3; f++)
         for (int o = 0; o < 8; o++)
            for (int xi = 0; xi < 16; xi++)
               for (int y = 0; y < 128; y++)
                  do_req(f, o, xi * 17, y);

      // oversized coordinates (R6)
      for (int f = 0; f < 3; f++) begin
         do_req(f, 0, 65535, 0);
         do_req(f, 5, 0, 65535);
         do_req(f, 2, 256, 3);
         do_req(f, 7, 1, 128);
      end
      // 32-bit x boundary: 127 fits, 128 does not (R5)
      do_req(2, 0, 127, 63);
      do_req(2, 0, 128, 0);

      // page mode (R10)
      do_req(3, 0, 0, 0);
      do_req(3, 6, 10, 20);
      do_req(3, 3, 255, 127);

      // hold between requests (R1)
      do_req(1, 6, 33, 21);
      model(1, 6, 33, 21, a0, e0, s0);
      @(negedge clk);
      req_fmt = 2'd3; req_orient = 3'd1; req_x = 16'd9; req_y = 16'd9;
      @(negedge clk);
      chk("R1 idle valid", {31'd0, rsp_valid}, 32'd0);
      chk("R1 hold addr", rsp_addr, a0);
      chk("R1 hold stride", rsp_stride, s0);
      chk("R1 hold err", {31'd0, rsp_range_err}, {31'd0, e0});

      finish_run();
   end

endmodule